// File: doc/BRIEF.md
# Dual-Lane 0011 Pattern Detector

This block watches two serial bit lanes, `in_a` and `in_b`, that are sampled together on each rising clock edge. It raises `match_o` when both lanes have carried the bit pattern 0, 0, 1, 1 over the same four consecutive clock periods. The first bit of the pattern arrives first. The lanes must agree in every one of those periods. A period in which the two lanes carry different bits breaks any partial match.

`match_o` is a Mealy output. It is a combinational function of the stored state and the lane values of the current period, so it goes high during the period that carries the fourth bit, not one cycle later. Internally, each period's lane pair is classified as one of three symbols: both zero (`SYM_ZERO`), both one (`SYM_ONE`) or split (`SYM_SPLIT`).

The state machine has four states, each named for the longest prefix of the pattern matched so far:
- `ST_IDLE`: nothing matched.
- `ST_Z`: "0" matched.
- `ST_ZZ`: "00" matched.
- `ST_ZZO`: "001" matched.

Its transitions are:
- From `ST_IDLE`, a `SYM_ZERO` pair moves to `ST_Z`.
- From `ST_Z`, a `SYM_ZERO` pair moves to `ST_ZZ`.
- In `ST_ZZ`, a `SYM_ZERO` pair keeps the machine in `ST_ZZ`, and a `SYM_ONE` pair moves it to `ST_ZZO`.
- From `ST_ZZO`, a `SYM_ONE` pair completes the match and returns to `ST_IDLE`, while a `SYM_ZERO` pair falls back to `ST_Z`.
- Every other symbol, including every `SYM_SPLIT`, returns the machine to `ST_IDLE`.

Top module: `pair_seq_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes `ST_IDLE`. `match_o` is 0 whenever `rst` is high, whatever the lane values.
- R2: `match_o` is 1 in the period whose lane values are (1,1) when the three preceding sampled periods since reset carried (0,0), (0,0) and (1,1), oldest first.
- R3: A period with `in_a` different from `in_b` returns the machine to `ST_IDLE`. No match is reported for any four-period window that contains such a period.
- R4: A run of three or more (0,0) periods followed by (1,1), (1,1) still produces a match on the last (1,1).
- R5: After a match the machine is in `ST_IDLE`. Two back-to-back patterns (eight periods) produce two matches, and a (1,1) period right after a match gives no match.
- R6: In `ST_ZZO`, a (0,0) period falls back to `ST_Z`. The stream 0,0,1,0,0,1,1 therefore matches on its final bit.
- R7: `match_o` is 0 in every period not covered by R2. In particular, (1,1) with fewer than three sampled periods since reset gives no match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Serial lane A, one bit per period |
| in_b | input | 1 | Serial lane B, one bit per period |
| match_o | output | 1 | High during the final period of a lockstep 0011 |

## Verification
The clean pattern and its long-zero-prefix variant show that the `ST_ZZ` self-loop is present. Back-to-back patterns and 0010011 separate the correct post-match and `ST_ZZO`-on-zero targets from plausible wrong ones. Streams in which the lanes split at each pattern position in turn show that a disagreement is never treated as a zero or a one. A long random stream, biased toward agreeing lanes, is compared every period against a shift-register model of the last four pairs.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
    localparam int STATE_W = 2;
    localparam int SYM_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 2'd0,
        ST_Z    = 2'd1,
        ST_ZZ   = 2'd2,
        ST_ZZO  = 2'd3
    } det_state_t;

    typedef enum logic [SYM_W-1:0] {
        SYM_ZERO  = 2'd0,
        SYM_ONE   = 2'd1,
        SYM_SPLIT = 2'd2
    } pair_sym_t;
endpackage

// File: rtl/pair_classify.sv
module pair_classify
    import seqdet_pkg::*;
(
    input  logic      a,
    input  logic      b,
    output pair_sym_t sym
);
    always_comb begin
        if (a != b)
            sym = SYM_SPLIT;
        else if (a)
            sym = SYM_ONE;
        else
            sym = SYM_ZERO;
    end
endmodule

// File: rtl/seq_next.sv
module seq_next
    import seqdet_pkg::*;
(
    input  det_state_t cur,
    input  pair_sym_t  sym,
    output det_state_t nxt,
    output logic       hit
);
    always_comb begin
        nxt = ST_IDLE;
        hit = 1'b0;
        unique case (cur)
            ST_IDLE: begin
                if (sym == SYM_ZERO) nxt = ST_Z;
            end
            ST_Z: begin
                if (sym == SYM_ZERO) nxt = ST_ZZ;
            end
            ST_ZZ: begin
                if (sym == SYM_ZERO)     nxt = ST_ZZ;
                else if (sym == SYM_ONE) nxt = ST_ZZO;
            end
            ST_ZZO: begin
                if (sym == SYM_ZERO) nxt = ST_Z;
                else if (sym == SYM_ONE) begin
                    nxt = ST_IDLE;
                    hit = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pair_seq_detector.sv
module pair_seq_detector
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    output logic match_o
);
    pair_sym_t  sym;
    det_state_t state_q;
    det_state_t state_d;
    logic       hit;

    pair_classify u_cls (
        .a   (in_a),
        .b   (in_b),
        .sym (sym)
    );

    seq_next u_nxt (
        .cur (state_q),
        .sym (sym),
        .nxt (state_d),
        .hit (hit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        match_o = hit & ~rst;
    end
endmodule

// File: rtl/seqdet_checks.sv
module seqdet_checks
    import seqdet_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_a,
    input logic       in_b,
    input logic       match_o,
    input det_state_t state
);
    always_comb begin
        if (rst === 1'b1)
            p_quiet_in_reset_r1: assert (match_o == 1'b0);
    end

    p_match_history_r2: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (in_a && in_b && $past(in_a) && $past(in_b)
                     && !$past(in_a, 2) && !$past(in_b, 2)
                     && !$past(in_a, 3) && !$past(in_b, 3)));

    p_split_to_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (in_a != in_b) |=> (state == ST_IDLE));

    p_zero_run_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ZZ && !in_a && !in_b) |=> (state == ST_ZZ));

    p_idle_after_match_r5: assert property (@(posedge clk) disable iff (rst)
        match_o |=> (state == ST_IDLE));

    p_fallback_on_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ZZO && !in_a && !in_b) |=> (state == ST_Z));

    p_match_only_from_zzo_r7: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (state == ST_ZZO));
endmodule

bind pair_seq_detector seqdet_checks u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_a    (in_a),
    .in_b    (in_b),
    .match_o (match_o),
    .state   (state_q)
);

// File: tb/sim_pair_seq_detector.sv
module sim_pair_seq_detector;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_a = 1'b0;
    logic in_b = 1'b0;
    logic match_o;

    int vectors = 0;
    int errors  = 0;
    logic [2:0] ha = '0, hb = '0;
    int valid = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pair_seq_detector u0 (
        .clk     (clk),
        .rst     (rst),
        .in_a    (in_a),
        .in_b    (in_b),
        .match_o (match_o)
    );

    task automatic step(input logic a, input logic b, input string req);
        logic exp;
        @(negedge clk);
        in_a = a;
        in_b = b;
        #1;
        exp = !rst && valid >= 3 && a && b && ha == 3'b001 && hb == 3'b001;
        vectors++;
        if (match_o !== exp) begin
            errors++;
            $display("FAIL %s: in=(%0b,%0b) match_o=%0b expected %0b", req, a, b, match_o, exp);
        end
        @(posedge clk);
        if (rst) begin
            ha = '0; hb = '0; valid = 0;
        end else begin
            ha = {ha[1:0], a};
            hb = {hb[1:0], b};
            if (valid < 3) valid++;
        end
    endtask

    task automatic both(input logic [15:0] bits, input int n, input string req);
        for (int i = n - 1; i >= 0; i--) step(bits[i], bits[i], req);
    endtask

    task automatic expect_hit(input logic want, input string req);
        vectors++;
        if (match_o !== want) begin
            errors++;
            $display("FAIL %s: match_o=%0b expected %0b", req, match_o, want);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1, 1, "R1");
        step(0, 0, "R1");
        step(1, 1, "R1");
        rst = 1'b0;
    endtask

    task automatic t_reset_during_pattern();
        both(16'b001, 3, "R1");
        rst = 1'b1;
        step(1, 1, "R1");
        rst = 1'b0;
        step(1, 1, "R1");
    endtask

    task automatic t_basic();
        both(16'b0011, 4, "R2");
        expect_hit(1'b1, "R2");
    endtask

    task automatic t_splits();
        for (int pos = 0; pos < 4; pos++) begin
            both(16'b1, 1, "R3");
            for (int k = 0; k < 4; k++) begin
                logic bit_v = (k >= 2);
                if (k == pos) step(bit_v, ~bit_v, "R3");
                else          step(bit_v, bit_v, "R3");
            end
            expect_hit(1'b0, "R3");
        end
        step(0, 1, "R3");
        both(16'b011, 3, "R3");
        expect_hit(1'b0, "R3");
    endtask

    task automatic t_long_zeros();
        both(16'b1, 1, "R4");
        both(16'b0000011, 7, "R4");
        expect_hit(1'b1, "R4");
    endtask

    task automatic t_back_to_back();
        both(16'b0011, 4, "R5");
        expect_hit(1'b1, "R5");
        both(16'b0011, 4, "R5");
        expect_hit(1'b1, "R5");
        both(16'b1, 1, "R5");
        expect_hit(1'b0, "R5");
    endtask

    task automatic t_fallback();
        both(16'b1, 1, "R6");
        both(16'b0010011, 7, "R6");
        expect_hit(1'b1, "R6");
    endtask

    task automatic t_early_ones();
        do_reset();
        both(16'b11, 2, "R7");
        expect_hit(1'b0, "R7");
        do_reset();
        both(16'b011, 3, "R7");
        expect_hit(1'b0, "R7");
    endtask

    task automatic t_random();
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 9);
            logic a = $urandom_range(0, 2) == 0;
            if (r == 0) step(a, ~a, "R7");
            else        step(a, a, "R7");
        end
    endtask

    initial begin
        do_reset();
        t_reset_during_pattern();
        t_basic();
        t_splits();
        t_long_zeros();
        t_back_to_back();
        t_fallback();
        t_early_ones();
        t_random();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule